// File: doc/BRIEF.md
# Hardware Loop Next-Address Sequencer

This block picks the address of the next instruction for a small program sequencer that runs loops with no branch overhead. A loop-setup instruction records three things in one cycle: where the loop body starts, where it ends with the rule that ends it, and an optional iteration count. Each of these goes onto its own four-entry stack, so loops can nest. When the current address equals the end address on top of the loop stack, the block either jumps back to the body start or falls through to the next address. When it falls through, it discards the loop's stack entries.

An explicit jump, call or return whose own condition holds at the loop's last address takes precedence. When that happens, every loop-end action is skipped. An idle instruction stops the sequencer until an interrupt arrives. If the idle sat at the loop's last address, the interrupt also ends the loop. The surrounding pipeline feeds the next address back as the current address. The same program-address stack also serves calls and returns.

Top module: `zol_seq`

## Requirements
- R1: After reset, `idle`, `ovf` and `unf` are low and all stacks are empty. An `op` of 0 (sequential), or of 6 or 7, gives `next_pc = pc + 1` when no loop end is hit.
- R2: `op` 5 (loop setup) gives `next_pc = pc + 1`. It pushes `pc + 1` onto the address stack and `{loop_end, loop_cond}` onto the loop stack. It also pushes `loop_count` onto the count stack when `loop_cond[3]` is 0.
- R3: When `pc` equals the loop-stack top end address, the instruction is sequential and the termination test is false: `next_pc` is the address-stack top. If the loop is counted, its top count drops by one.
- R4: Under the same loop-end conditions with the termination test true: `next_pc = pc + 1`. The address stack and loop stack are popped, and the count stack is popped too for a counted loop.
- R5: When `loop_cond[3]` is 0, the termination test is true if the top count equals 1 or the count stack is empty. When `loop_cond[3]` is 1, it is true when `flags[loop_cond[1:0]]` equals `loop_cond[2]`. The instruction's own `cond_ok` never enters this test.
- R6: A jump (`op` 1) or call (`op` 2) with `cond_ok` high goes to `target`, and a call pushes `pc + 1`. At a loop end, no loop stack or count stack entry is popped or decremented.
- R7: A return (`op` 3) with `cond_ok` high goes to the address-stack top, or to `pc + 1` if that stack is empty. It pops that stack except at a loop end, where the stack is kept, so control goes back to the loop start.
- R8: A jump, call or return with `cond_ok` low behaves as a sequential instruction, including normal loop-end sequencing.
- R9: `op` 4 (idle) gives `next_pc = pc` and raises `idle` from the next cycle. While `idle` is high and `irq` is low, `next_pc = pc` and no stack changes. `irq` has no effect while `idle` is low.
- R10: `irq` while `idle` is high clears `idle` on the next cycle. If the idle was at a loop end, `next_pc` is that end address plus 1 and the loop's entries are popped as in R4. Otherwise `next_pc = pc + 1`.
- R11: A push onto a full stack (4 entries) is dropped and sets `ovf`, which stays high until reset.
- R12: A pop of an empty stack is ignored and sets `unf`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc | input | AW | Address of the current instruction |
| op | input | 3 | Instruction class: 0 seq, 1 jump, 2 call, 3 return, 4 idle, 5 loop setup |
| cond_ok | input | 1 | Result of the instruction's own condition |
| target | input | AW | Jump or call destination |
| loop_end | input | AW | Last address of the loop being set up |
| loop_cond | input | 4 | Termination rule of the loop being set up |
| loop_count | input | CW | Iteration count of the loop being set up |
| flags | input | 4 | Status flags |
| irq | input | 1 | Interrupt request |
| next_pc | output | AW | Address of the next instruction |
| idle | output | 1 | Low-power wait-for-interrupt state |
| ovf | output | 1 | Sticky stack overflow |
| unf | output | 1 | Sticky stack underflow |

## Verification
Two functions can fall in the same cycle: the loop-end decision and an explicit jump, call, return or idle sitting at the loop's last address. Directed sequences put each transfer type at a loop end with its condition both true and false. Later loop ends show whether the count was left alone and whether the body start survived. Random stimulus places loop ends one to four words ahead and mixes in conditional transfers, idles and interrupts. Every cycle's next address and flags are compared against a bench model built from the requirements.

// File: rtl/zol_seq.sv
module zol_seq #(
  parameter int AW    = 12,
  parameter int CW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc,
  input  logic [2:0]    op,
  input  logic          cond_ok,
  input  logic [AW-1:0] target,
  input  logic [AW-1:0] loop_end,
  input  logic [3:0]    loop_cond,
  input  logic [CW-1:0] loop_count,
  input  logic [3:0]    flags,
  input  logic          irq,
  output logic [AW-1:0] next_pc,
  output logic          idle,
  output logic          ovf,
  output logic          unf
);
  localparam int DW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);
  localparam int LW = AW + 4;
  localparam logic [2:0] OP_JMP = 3'd1, OP_CALL = 3'd2, OP_RET = 3'd3,
                         OP_IDLE = 3'd4, OP_SETUP = 3'd5;

  logic [AW-1:0] pstk [DEPTH];
  logic [LW-1:0] lstk [DEPTH];
  logic [CW-1:0] cstk [DEPTH];
  logic [DW-1:0] pd, ld, cd;
  logic          iend;

  logic [DW-1:0] pm1, lm1, cm1;
  assign pm1 = pd - DW'(1);
  assign lm1 = ld - DW'(1);
  assign cm1 = cd - DW'(1);

  logic [AW-1:0] ptop, lend, pc_inc;
  logic [3:0]    lcode;
  logic [CW-1:0] ctop;
  assign ptop  = (pd != '0) ? pstk[pm1[IW-1:0]] : '0;
  assign lend  = (ld != '0) ? lstk[lm1[IW-1:0]][LW-1:4] : '0;
  assign lcode = (ld != '0) ? lstk[lm1[IW-1:0]][3:0] : '0;
  assign ctop  = (cd != '0) ? cstk[cm1[IW-1:0]] : '0;
  assign pc_inc = pc + AW'(1);

  logic hit, ucnt, term, is_x, taken, run, wake, lpass;
  assign hit   = (ld != '0) && (pc == lend);
  assign ucnt  = !lcode[3];
  assign term  = ucnt ? ((cd == '0) || (ctop == CW'(1)))
                      : (flags[lcode[1:0]] == lcode[2]);
  assign is_x  = (op == OP_JMP) || (op == OP_CALL) || (op == OP_RET);
  assign taken = is_x && cond_ok;
  assign run   = !idle;
  assign wake  = idle && irq;
  assign lpass = run && hit && !taken && (op != OP_IDLE) && (op != OP_SETUP);

  logic p_push, p_pop, l_push, l_pop, c_push, c_pop, c_dec;
  assign p_push = run && ((op == OP_SETUP) || (taken && op == OP_CALL));
  assign p_pop  = (run && ((taken && op == OP_RET && !hit) || (lpass && term))) ||
                  (wake && iend);
  assign l_push = run && (op == OP_SETUP);
  assign l_pop  = (lpass && term) || (wake && iend);
  assign c_push = l_push && !loop_cond[3];
  assign c_pop  = l_pop && ucnt;
  assign c_dec  = lpass && !term && ucnt && (cd != '0);

  always_comb begin
    if (idle)                next_pc = irq ? (iend ? lend + AW'(1) : pc_inc) : pc;
    else if (op == OP_SETUP) next_pc = pc_inc;
    else if (op == OP_IDLE)  next_pc = pc;
    else if (taken)          next_pc = (op == OP_RET) ? ((pd != '0) ? ptop : pc_inc) : target;
    else if (hit)            next_pc = term ? pc_inc : ptop;
    else                     next_pc = pc_inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd <= '0; ld <= '0; cd <= '0;
      idle <= 1'b0; iend <= 1'b0; ovf <= 1'b0; unf <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        pstk[i] <= '0; lstk[i] <= '0; cstk[i] <= '0;
      end
    end else begin
      if (p_push) begin
        if (pd != DW'(DEPTH)) begin pstk[pd[IW-1:0]] <= pc_inc; pd <= pd + DW'(1); end
      end else if (p_pop && pd != '0) pd <= pm1;

      if (l_push) begin
        if (ld != DW'(DEPTH)) begin lstk[ld[IW-1:0]] <= {loop_end, loop_cond}; ld <= ld + DW'(1); end
      end else if (l_pop && ld != '0) ld <= lm1;

      if (c_push) begin
        if (cd != DW'(DEPTH)) begin cstk[cd[IW-1:0]] <= loop_count; cd <= cd + DW'(1); end
      end else if (c_pop && cd != '0) cd <= cm1;
      else if (c_dec) cstk[cm1[IW-1:0]] <= ctop - CW'(1);

      if (run && op == OP_IDLE) begin idle <= 1'b1; iend <= hit; end
      else if (wake) idle <= 1'b0;

      ovf <= ovf | (p_push && pd == DW'(DEPTH)) | (l_push && ld == DW'(DEPTH)) |
             (c_push && cd == DW'(DEPTH));
      unf <= unf | (p_pop && pd == '0) | (l_pop && ld == '0) | (c_pop && cd == '0);
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> ovf); // R11
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) unf |=> unf); // R12
  AST_SETUP_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == OP_SETUP && ld != DW'(DEPTH)) |=> ld == $past(ld) + DW'(1)); // R2
  AST_TAKEN_KEEPS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hit && taken) |=> (ld == $past(ld)) && (cd == $past(cd)) && (ctop == $past(ctop))); // R6
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !irq) |=> idle && $stable(pd) && $stable(ld) && $stable(cd)); // R9
  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && irq) |=> !idle); // R10
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (pd <= DW'(DEPTH)) && (ld <= DW'(DEPTH)) && (cd <= DW'(DEPTH))); // R11
endmodule

// File: tb/zol_seq_test.sv
`timescale 1ns/1ps
module zol_seq_test;
  localparam int AW = 12, CW = 8, D = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] pc = '0, target = '0, loop_end = '0, next_pc;
  logic [2:0] op = '0;
  logic cond_ok = 1'b0, irq = 1'b0, idle, ovf, unf;
  logic [3:0] loop_cond = '0, flags = '0;
  logic [CW-1:0] loop_count = '0;

  always #2.5 clk = ~clk;

  zol_seq #(.AW(AW), .CW(CW), .DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .pc(pc), .op(op), .cond_ok(cond_ok), .target(target),
    .loop_end(loop_end), .loop_cond(loop_cond), .loop_count(loop_count), .flags(flags),
    .irq(irq), .next_pc(next_pc), .idle(idle), .ovf(ovf), .unf(unf));

  logic [AW-1:0] mp [D];
  logic [AW+3:0] ml [D];
  logic [CW-1:0] mc [D];
  int mpd, mld, mcd;
  bit mi, mie, mo, mu;
  logic [AW-1:0] mpc;
  int checks = 0, errors = 0;

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic ppush(logic [AW-1:0] v); if (mpd == D) mo = 1; else begin mp[mpd] = v; mpd++; end endtask
  task automatic lpush(logic [AW+3:0] v); if (mld == D) mo = 1; else begin ml[mld] = v; mld++; end endtask
  task automatic cpush(logic [CW-1:0] v); if (mcd == D) mo = 1; else begin mc[mcd] = v; mcd++; end endtask
  task automatic ppop(); if (mpd == 0) mu = 1; else mpd--; endtask
  task automatic lpop(); if (mld == 0) mu = 1; else mld--; endtask
  task automatic cpop(); if (mcd == 0) mu = 1; else mcd--; endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; op = '0; irq = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    mpd = 0; mld = 0; mcd = 0; mi = 0; mie = 0; mo = 0; mu = 0;
  endtask

  task automatic step(int o, bit c, int tg, int le, int lc, int cnt, int fl, bit ir, int want);
    logic [AW-1:0] en, inc, ptop, lend;
    logic [3:0] lcd;
    bit hit, uc, term, xf;
    string t;
    @(negedge clk);
    pc = mpc; op = 3'(o); cond_ok = c; target = AW'(tg); loop_end = AW'(le);
    loop_cond = 4'(lc); loop_count = CW'(cnt); flags = 4'(fl); irq = ir;
    #1;
    chk("R9 idle", int'(idle), int'(mi));
    chk("R11 ovf", int'(ovf), int'(mo));
    chk("R12 unf", int'(unf), int'(mu));
    inc  = mpc + 1'b1;
    ptop = (mpd > 0) ? mp[mpd-1] : '0;
    lend = (mld > 0) ? ml[mld-1][AW+3:4] : '0;
    lcd  = (mld > 0) ? ml[mld-1][3:0] : '0;
    hit  = (mld > 0) && (mpc == lend);
    uc   = !lcd[3];
    term = uc ? (mcd == 0 || mc[mcd-1] == 1) : (flags[lcd[1:0]] == lcd[2]);
    xf   = (o >= 1 && o <= 3);
    if (mi) begin
      t = ir ? "R10" : "R9";
      if (!ir) en = mpc;
      else begin
        mi = 0;
        if (mie) begin en = lend + 1'b1; ppop(); lpop(); if (uc) cpop(); end
        else en = inc;
      end
    end else if (o == 5) begin
      t = "R2"; en = inc; ppush(inc); lpush({AW'(le), 4'(lc)});
      if (!lc[3]) cpush(CW'(cnt));
    end else if (o == 4) begin
      t = "R9"; en = mpc; mi = 1; mie = hit;
    end else if (xf && c) begin
      t = "R6";
      if (o == 1) en = AW'(tg);
      else if (o == 2) begin en = AW'(tg); ppush(inc); end
      else begin
        t = "R7"; en = (mpd > 0) ? ptop : inc;
        if (!hit) ppop();
      end
    end else if (hit) begin
      t = xf ? "R8" : (uc ? (term ? "R4" : "R3") : "R5");
      if (term) begin en = inc; ppop(); lpop(); if (uc) cpop(); end
      else begin en = ptop; if (uc && mcd > 0) mc[mcd-1] = mc[mcd-1] - 1'b1; end
    end else begin
      t = xf ? "R8" : "R1"; en = inc;
    end
    chk({t, " next_pc"}, int'(next_pc), int'(en));
    if (want >= 0) chk({t, " directed"}, int'(next_pc), want);
    @(posedge clk);
    mpc = en;
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    do_reset();
    #1;
    chk("R1 reset idle", int'(idle), 0);
    chk("R1 reset ovf", int'(ovf), 0);
    chk("R1 reset unf", int'(unf), 0);
    mpc = 100;
    step(0, 0, 0, 0, 0, 0, 0, 0, 101);          // R1
    step(5, 0, 0, 103, 0, 2, 0, 0, 102);        // R2 counted loop
    step(0, 0, 0, 0, 0, 0, 0, 0, 103);
    step(0, 0, 0, 0, 0, 0, 0, 0, 102);          // R3
    step(0, 0, 0, 0, 0, 0, 0, 0, 103);
    step(0, 0, 0, 0, 0, 0, 0, 0, 104);          // R4
    step(5, 0, 0, 106, 4'b1101, 0, 0, 0, 105);  // R5 flag loop
    step(0, 0, 0, 0, 0, 0, 0, 0, 106);
    step(0, 0, 0, 0, 0, 0, 4'b0000, 0, 105);    // R5 false
    step(0, 0, 0, 0, 0, 0, 0, 0, 106);
    step(0, 0, 0, 0, 0, 0, 4'b0010, 0, 107);    // R5 true
    step(5, 0, 0, 109, 0, 3, 0, 0, 108);
    step(0, 0, 0, 0, 0, 0, 0, 0, 109);
    step(1, 1, 200, 0, 0, 0, 0, 0, 200);        // R6 jump at end
    step(1, 1, 108, 0, 0, 0, 0, 0, 108);
    step(0, 0, 0, 0, 0, 0, 0, 0, 109);
    step(2, 0, 300, 0, 0, 0, 0, 0, 108);        // R8 call false at end
    step(0, 0, 0, 0, 0, 0, 0, 0, 109);
    step(3, 1, 0, 0, 0, 0, 0, 0, 108);          // R7 return at end
    step(0, 0, 0, 0, 0, 0, 0, 0, 109);
    step(0, 0, 0, 0, 0, 0, 0, 0, 108);          // R6 count untouched by jump/return
    step(0, 0, 0, 0, 0, 0, 0, 0, 109);
    step(0, 0, 0, 0, 0, 0, 0, 0, 110);          // R4
    step(5, 0, 0, 111, 0, 5, 0, 0, 111);
    step(4, 0, 0, 0, 0, 0, 0, 0, 111);          // R9 idle at end
    step(0, 0, 0, 0, 0, 0, 0, 0, 111);          // R9 hold
    step(0, 0, 0, 0, 0, 0, 0, 1, 112);          // R10 wake ends loop
    step(0, 0, 0, 0, 0, 0, 0, 0, 113);
    step(4, 0, 0, 0, 0, 0, 0, 0, 113);
    step(0, 0, 0, 0, 0, 0, 0, 1, 114);          // R10 wake outside loop
    step(3, 1, 0, 0, 0, 0, 0, 0, 115);          // R12 return on empty stack
    step(0, 0, 0, 0, 0, 0, 0, 1, 116);          // R9 irq ignored when awake
    #1 chk("R12 unf set", int'(unf), 1);
    chk("R9 irq ignored", int'(idle), 0);
    for (int k = 0; k < 4; k++) step(5, 0, 0, 500, 0, 1, 0, 0, 116 + k + 1);
    #1 chk("R11 no ovf at depth", int'(ovf), 0);
    step(5, 0, 0, 500, 0, 1, 0, 0, 121);
    #1 chk("R11 ovf set", int'(ovf), 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 122);
    #1 chk("R11 ovf sticky", int'(ovf), 1);

    for (int n = 0; n < 4000; n++) begin
      int r, o;
      if (n % 500 == 0) begin do_reset(); mpc = AW'(16 + $urandom % 64); end
      r = $urandom % 100;
      o = (r < 45) ? 0 : (r < 57) ? 5 : (r < 65) ? 1 : (r < 73) ? 2 :
          (r < 81) ? 3 : (r < 86) ? 4 : 6 + (r % 2);
      step(o, bit'($urandom % 2), int'(mpc) + 1 + int'($urandom % 6) - 3,
           int'(mpc) + 1 + int'($urandom % 4), int'($urandom % 16),
           1 + int'($urandom % 4), int'($urandom % 16), bit'(($urandom % 4) == 0), -1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule